// File: doc/BRIEF.md
# GPIO Bank External Interrupt Controller

This block turns pad levels on one or more 32-line GPIO banks into interrupt requests. Every line carries a 4-bit trigger code that picks rising edge, falling edge, high level, low level or both edges. A line is eligible only when its pin-mux function code selects interrupt routing. Pad inputs cross into the clock domain through a two-flop synchronizer. Detected conditions set sticky per-line status bits. Each bank drives one interrupt output, which goes high when any enabled line has its status bit set.

Software reaches the controller over a simple word-wide register bus with a write strobe and a combinational read port. Each bank owns a 32-byte window. The first window begins at byte address 0x200 plus a configurable bank base times 0x20. Inside a window the four trigger-config words come first, followed by the enable word, the status word and a debounce setting word. The debounce setting is only stored for a clock-source selector outside this block.

Top module: `gpio_eint_ctrl`

## Requirements
- R1: A pad change first sampled at clock edge n is reflected in the status bit after edge n+2 and not before.
- R2: Trigger code 0 sets status on a rising synchronized level, 1 on a falling one, 2 while high, 3 while low, and 4 on either edge.
- R3: Trigger codes 5 to 15 never set status.
- R4: A line sets status only when its 4-bit mux field (bits 4l+3..4l of the bank's slice of mux_i) equals 6; any other code, including 0 (plain input), blocks it even when enabled.
- R5: Status bits are sticky and are cleared by writing 1 to them at window offset 0x14; an event in the same cycle as the clearing write keeps the bit set.
- R6: A level-triggered status bit is set again immediately after clearing while its level condition persists.
- R7: irq_o[b] equals the OR over the 32 lines of status AND enable of bank b, and the enable word sits at window offset 0x10.
- R8: Bank b's window starts at 0x200 + (BANK_BASE+b)*0x20. Config words are at offsets 0x00..0x0C, and line l uses bits 4(l%8)+3..4(l%8) of word l/8. The debounce word at 0x18 keeps the low DEB_W bits and reads zero above them. Unmapped offsets read 0.
- R9: After reset every register reads 0 and every irq_o bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| pad_i | input | NUM_BANKS*32 | Asynchronous pad levels, line l of bank b at bit 32b+l |
| mux_i | input | NUM_BANKS*128 | Pin-mux function codes, 4 bits per line |
| irq_o | output | NUM_BANKS | Per-bank interrupt request |

## Verification
The hardest case to reach is a clearing write that lands on the exact edge where a fresh edge event sets the same bit. An off-by-one in either path would still pass every ordinary test. The stimulus counts the synchronizer stages: it raises the pad, waits two falling edges, and then issues the write so that it commits on the edge where the status update happens. The level re-assert case is reached in a similar way. The clearing write is issued while the synchronized level still meets the condition. A per-cycle behavioural model catches any mismatch of the interrupt outputs during all of this.

// File: rtl/gpio_eint_pkg.sv
package gpio_eint_pkg;
  localparam int LINES       = 32;
  localparam int CODE_W      = 4;
  localparam int CFG_PER_REG = 8;
  localparam int CFG_REGS    = LINES / CFG_PER_REG;
  localparam int WIN_BASE    = 'h200;
  localparam int WIN_STRIDE  = 'h20;

  localparam logic [4:0] OFS_EN  = 5'h10;
  localparam logic [4:0] OFS_ST  = 5'h14;
  localparam logic [4:0] OFS_DEB = 5'h18;

  localparam logic [CODE_W-1:0] FUNC_EINT = 4'd6;

  typedef enum logic [CODE_W-1:0] {
    TRIG_RISE = 4'd0,
    TRIG_FALL = 4'd1,
    TRIG_HIGH = 4'd2,
    TRIG_LOW  = 4'd3,
    TRIG_BOTH = 4'd4
  } trig_e;
endpackage

// File: rtl/gpio_eint_sync.sv
module gpio_eint_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_eint_detect.sv
module gpio_eint_detect
  import gpio_eint_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [LINES-1:0]         lvl_i,
  input  logic [LINES*CODE_W-1:0]  cfg_i,
  input  logic [LINES*CODE_W-1:0]  mux_i,
  output logic [LINES-1:0]         hit_o
);
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic raw;
    always_comb begin
      case (cfg_i[l*CODE_W +: CODE_W])
        TRIG_RISE: raw = lvl_i[l] & ~prev_q[l];
        TRIG_FALL: raw = ~lvl_i[l] & prev_q[l];
        TRIG_HIGH: raw = lvl_i[l];
        TRIG_LOW:  raw = ~lvl_i[l];
        TRIG_BOTH: raw = lvl_i[l] ^ prev_q[l];
        default:   raw = 1'b0;  // reserved codes
      endcase
    end
    assign hit_o[l] = raw & (mux_i[l*CODE_W +: CODE_W] == FUNC_EINT);
  end
endmodule

// File: rtl/gpio_eint_bank.sv
module gpio_eint_bank
  import gpio_eint_pkg::*;
#(
  parameter int DEB_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [4:0]              off_i,
  input  logic [31:0]             wdata_i,
  input  logic [LINES-1:0]        lvl_i,
  input  logic [LINES*CODE_W-1:0] mux_i,
  output logic [31:0]             rdata_o,
  output logic [LINES*CODE_W-1:0] cfg_o,
  output logic [LINES-1:0]        en_o,
  output logic [LINES-1:0]        st_o,
  output logic                    irq_o
);
  localparam int IDX_W = $clog2(CFG_REGS);

  logic [CFG_REGS-1:0][31:0] cfg_q;
  logic [LINES-1:0]          en_q, st_q, hit, clr;
  logic [DEB_W-1:0]          deb_q;

  logic sel_cfg, sel_en, sel_st, sel_deb;
  assign sel_cfg = wr_i && (off_i[4] == 1'b0);
  assign sel_en  = wr_i && (off_i == OFS_EN);
  assign sel_st  = wr_i && (off_i == OFS_ST);
  assign sel_deb = wr_i && (off_i == OFS_DEB);
  assign clr     = sel_st ? wdata_i[LINES-1:0] : '0;

  gpio_eint_detect u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_i),
    .cfg_i (cfg_o),
    .mux_i (mux_i),
    .hit_o (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      en_q  <= '0;
      st_q  <= '0;
      deb_q <= '0;
    end else begin
      if (sel_cfg) cfg_q[off_i[IDX_W+1:2]] <= wdata_i;
      if (sel_en)  en_q  <= wdata_i[LINES-1:0];
      if (sel_deb) deb_q <= wdata_i[DEB_W-1:0];
      st_q <= (st_q & ~clr) | hit;  // new event wins over clear
    end
  end

  always_comb begin
    case (off_i[4:2])
      3'd0, 3'd1, 3'd2, 3'd3: rdata_o = cfg_q[off_i[IDX_W+1:2]];
      3'd4:    rdata_o = en_q;
      3'd5:    rdata_o = st_q;
      3'd6:    rdata_o = {{(32-DEB_W){1'b0}}, deb_q};
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;
  assign en_o  = en_q;
  assign st_o  = st_q;
  assign irq_o = |(st_q & en_q);
endmodule

// File: rtl/gpio_eint_ctrl.sv
module gpio_eint_ctrl
  import gpio_eint_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_BASE = 0,
  parameter int ADDR_W    = 12,
  parameter int DEB_W     = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [31:0]                       wdata_i,
  output logic [31:0]                       rdata_o,
  input  logic [NUM_BANKS*LINES-1:0]        pad_i,
  input  logic [NUM_BANKS*LINES*CODE_W-1:0] mux_i,
  output logic [NUM_BANKS-1:0]              irq_o
);
  localparam int WIN0 = WIN_BASE + BANK_BASE * WIN_STRIDE;
  localparam int SPAN = NUM_BANKS * WIN_STRIDE;
  localparam int BSEL_W = ADDR_W - 5;

  logic [ADDR_W-1:0]                 rel;
  logic                              in_rng;
  logic [NUM_BANKS*LINES-1:0]        lvl, st_all, en_all;
  logic [NUM_BANKS*LINES*CODE_W-1:0] cfg_all;
  logic [NUM_BANKS-1:0][31:0]        rd_b;
  logic [NUM_BANKS-1:0]              sel_b;

  assign rel    = addr_i - ADDR_W'(WIN0);
  assign in_rng = (addr_i >= ADDR_W'(WIN0)) && (rel < ADDR_W'(SPAN));

  gpio_eint_sync #(.WIDTH(NUM_BANKS*LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pad_i),
    .sync_o (lvl)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign sel_b[b] = in_rng && (rel[ADDR_W-1:5] == BSEL_W'(b));
    gpio_eint_bank #(.DEB_W(DEB_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_en_i && sel_b[b]),
      .off_i  (rel[4:0]),
      .wdata_i(wdata_i),
      .lvl_i  (lvl[b*LINES +: LINES]),
      .mux_i  (mux_i[b*LINES*CODE_W +: LINES*CODE_W]),
      .rdata_o(rd_b[b]),
      .cfg_o  (cfg_all[b*LINES*CODE_W +: LINES*CODE_W]),
      .en_o   (en_all[b*LINES +: LINES]),
      .st_o   (st_all[b*LINES +: LINES]),
      .irq_o  (irq_o[b])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (sel_b[b]) rdata_o = rd_b[b];
  end
endmodule

// File: rtl/gpio_eint_chk.sv
module gpio_eint_chk
  import gpio_eint_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_BASE = 0,
  parameter int ADDR_W    = 12
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              wr_en_i,
  input logic [ADDR_W-1:0]                 addr_i,
  input logic [31:0]                       wdata_i,
  input logic [NUM_BANKS*LINES*CODE_W-1:0] mux_i,
  input logic [NUM_BANKS*LINES*CODE_W-1:0] cfg_all,
  input logic [NUM_BANKS*LINES-1:0]        st_all,
  input logic [NUM_BANKS*LINES-1:0]        en_all,
  input logic [NUM_BANKS-1:0]              irq_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    localparam logic [ADDR_W-1:0] ST_ADDR =
      ADDR_W'(WIN_BASE + (BANK_BASE + b) * WIN_STRIDE + int'(OFS_ST));

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_all[b*LINES +: LINES] == '0) |-> !irq_o[b]);  // R7

    for (genvar l = 0; l < LINES; l++) begin : g_l
      localparam int I = b*LINES + l;

      AST_SET_NEEDS_MUX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_all[I]) |-> $past(mux_i[I*CODE_W +: CODE_W] == FUNC_EINT));  // R4

      AST_RSVD_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_all[I]) |-> $past(cfg_all[I*CODE_W +: CODE_W] < 4'd5));  // R3

      AST_STICKY_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_all[I]) |-> $past(wr_en_i && addr_i == ST_ADDR && wdata_i[l]));  // R5
    end
  end
endmodule

bind gpio_eint_ctrl gpio_eint_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_BASE(BANK_BASE),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .mux_i  (mux_i),
  .cfg_all(cfg_all),
  .st_all (st_all),
  .en_all (en_all),
  .irq_o  (irq_o)
);

// File: tb/tb_gpio_eint_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_eint_ctrl;
  localparam int NB = 2;
  localparam int AW = 12;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            wr_en = 0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NB*32-1:0]  pad = '0;
  logic [NB*128-1:0] mux = '0;
  logic [NB-1:0]   irq;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_eint_ctrl #(.NUM_BANKS(NB), .BANK_BASE(0), .ADDR_W(AW), .DEB_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad), .mux_i(mux), .irq_o(irq)
  );

  // behavioural reference model
  bit [31:0] m_cfg [NB][4];
  bit [31:0] m_en [NB], m_st [NB], m_s1 [NB], m_s2 [NB], m_prev [NB];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_en[b] = 0; m_st[b] = 0; m_s1[b] = 0; m_s2[b] = 0; m_prev[b] = 0;
        for (int k = 0; k < 4; k++) m_cfg[b][k] = 0;
      end
    end else begin
      bit [31:0] set [NB];
      bit [31:0] clr [NB];
      for (int b = 0; b < NB; b++) begin
        set[b] = 0; clr[b] = 0;
        for (int l = 0; l < 32; l++) begin
          int code, fn;
          bit cur, old, ev;
          code = (m_cfg[b][l/8] >> ((l%8)*4)) & 15;
          fn   = mux[(b*32+l)*4 +: 4];
          cur  = m_s2[b][l]; old = m_prev[b][l];
          case (code)
            0: ev = cur && !old;
            1: ev = !cur && old;
            2: ev = cur;
            3: ev = !cur;
            4: ev = cur != old;
            default: ev = 0;
          endcase
          if (ev && fn == 6) set[b][l] = 1;
        end
      end
      if (wr_en && int'(addr) >= 'h200 && int'(addr) < 'h200 + NB*'h20) begin
        int b, o;
        b = (int'(addr) - 'h200) / 'h20;
        o = (int'(addr) - 'h200) % 'h20;
        if (o < 'h10) m_cfg[b][o/4] = wdata;
        else if (o == 'h10) m_en[b] = wdata;
        else if (o == 'h14) clr[b] = wdata;
      end
      for (int b = 0; b < NB; b++) begin
        m_st[b]   = (m_st[b] & ~clr[b]) | set[b];
        m_prev[b] = m_s2[b];
        m_s2[b]   = m_s1[b];
        m_s1[b]   = pad[b*32 +: 32];
      end
    end
  end

  // per-cycle comparison of the interrupt outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int b = 0; b < NB; b++) begin
        bit exp;
        exp = |(m_st[b] & m_en[b]);
        n_checks++;
        if (irq[b] !== exp) begin
          n_errors++;
          $display("FAIL R7 model irq bank %0d: actual %0b expected %0b", b, irq[b], exp);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = AW'(a); wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  task automatic set_mux(input int line, input logic [3:0] code);
    mux[line*4 +: 4] = code;
  endtask

  initial begin
    #(200000 * 8);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R9 reset state
    rd('h214, v); chk("R9 status after reset", v, 0);
    rd('h200, v); chk("R9 cfg after reset", v, 0);
    chk("R9 irq after reset", {30'b0, irq}, 0);

    // R1/R2 rising on line 3
    set_mux(3, 4'd6);
    wr('h210, 32'h8);
    pad[3] = 1;
    cyc(2);
    rd('h214, v); chk("R1 not yet set after two edges", v & 32'h8, 0);
    cyc(1);
    rd('h214, v); chk("R1 set after third edge", v & 32'h8, 32'h8);
    chk("R7 irq bank0 asserted", {31'b0, irq[0]}, 1);

    // R5 clear, rising mode ignores falling
    wr('h214, 32'h8);
    rd('h214, v); chk("R5 cleared by write-1", v & 32'h8, 0);
    pad[3] = 0; cyc(4);
    rd('h214, v); chk("R2 rising mode ignores fall", v & 32'h8, 0);

    // R2/R8 falling on line 9 (cfg word 1, field 1)
    wr('h204, 32'h10);
    set_mux(9, 4'd6);
    pad[9] = 1; cyc(4);
    rd('h214, v); chk("R2 falling ignores rise", v & 32'h200, 0);
    pad[9] = 0; cyc(4);
    rd('h214, v); chk("R2 falling sets", v & 32'h200, 32'h200);
    rd('h204, v); chk("R8 cfg word1 readback", v, 32'h10);

    // R6 high level on line 17 (word 2, field 1)
    wr('h208, 32'h20);
    set_mux(17, 4'd6);
    pad[17] = 1; cyc(4);
    wr('h214, 32'h20000);
    rd('h214, v); chk("R6 high level re-asserts", v & 32'h20000, 32'h20000);
    pad[17] = 0; cyc(4);
    wr('h214, 32'h20000);
    rd('h214, v); chk("R6 clears once level gone", v & 32'h20000, 0);

    // low level on line 26 (word 3, field 2)
    wr('h20C, 32'h300);
    set_mux(26, 4'd6);
    cyc(2);
    rd('h214, v); chk("R2 low level sets", v & 32'h4000000, 32'h4000000);
    pad[26] = 1; cyc(4);
    wr('h214, 32'h4000000);
    rd('h214, v); chk("R2 low level clears when high", v & 32'h4000000, 0);

    // both edges on line 30 (word 3, field 6)
    wr('h20C, 32'h0400_0300);
    set_mux(30, 4'd6);
    pad[30] = 1; cyc(4);
    rd('h214, v); chk("R2 both edges on rise", v & 32'h4000_0000, 32'h4000_0000);
    wr('h214, 32'h4000_0000);
    pad[30] = 0; cyc(4);
    rd('h214, v); chk("R2 both edges on fall", v & 32'h4000_0000, 32'h4000_0000);
    wr('h214, 32'h4000_0000);

    // R3 reserved codes 7 and 15 on lines 4 and 5
    wr('h200, 32'h00F7_0000);
    set_mux(4, 4'd6); set_mux(5, 4'd6);
    pad[4] = 1; pad[5] = 1; cyc(4);
    pad[4] = 0; pad[5] = 0; cyc(4);
    rd('h214, v); chk("R3 reserved codes never set", v & 32'h30, 0);

    // R4 mux gating: line 6 rising, mux 0 then 1
    wr('h210, 32'h48);
    pad[6] = 1; cyc(4);
    rd('h214, v); chk("R4 plain input blocks status", v & 32'h40, 0);
    set_mux(6, 4'd1);
    pad[6] = 0; cyc(4); pad[6] = 1; cyc(4);
    rd('h214, v); chk("R4 other function blocks status", v & 32'h40, 0);

    // R7 enable masking on line 3
    wr('h210, 32'h0);
    pad[3] = 1; cyc(4);
    rd('h214, v); chk("R7 status set while disabled", v & 32'h8, 32'h8);
    chk("R7 irq low while disabled", {31'b0, irq[0]}, 0);
    wr('h210, 32'h8);
    chk("R7 irq high once enabled", {31'b0, irq[0]}, 1);

    // R5 clear coinciding with a new rising event
    wr('h214, 32'h8);
    pad[3] = 0; cyc(4);
    pad[3] = 1;
    cyc(2);
    wr('h214, 32'h8);
    rd('h214, v); chk("R5 coincident event wins over clear", v & 32'h8, 32'h8);
    wr('h214, 32'h8);
    rd('h214, v); chk("R5 later clear succeeds", v & 32'h8, 0);

    // R8 bank 1 window
    set_mux(32, 4'd6);
    wr('h230, 32'h1);
    pad[32] = 1; cyc(4);
    rd('h234, v); chk("R8 bank1 status", v, 32'h1);
    chk("R8 bank1 irq", {31'b0, irq[1]}, 1);
    rd('h230, v); chk("R8 bank1 enable readback", v, 32'h1);

    // R8 debounce width and unmapped offset
    wr('h218, 32'hFFFF_FFFF);
    rd('h218, v); chk("R8 debounce keeps low bits", v, 32'hFF);
    rd('h21C, v); chk("R8 unmapped offset reads 0", v, 0);
    rd('h100, v); chk("R8 below window reads 0", v, 0);

    cyc(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule